// File: doc/BRIEF.md
# Byte-Writable SECDED SRAM Controller

This block sits between a single-master request bus and a 64-bit storage array whose every word carries eight check bits of a single-error-correcting, double-error-detecting Hamming code. A request is a read or a write with eight byte enables. A write that enables all eight bytes is committed at once, with check bits computed from the incoming data. Any narrower write (zero to seven enabled bytes) performs a read-modify-write. The controller reads the stored word, repairs it if needed, merges in the enabled bytes, recomputes the check bits and writes the word back.

Reads return corrected data. Each corrected or detected error pulses an alarm. An uncorrectable word makes the response carry an error flag. A small control interface can switch integrity checking off, for example while the array is being filled with narrow writes. It can also suppress the bus error flag, but only when a guard bit in the same control write is set. A merge that meets an uncorrectable word is dropped without touching the array. It also raises a sticky flag, which stays set until software clears it.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: A write with all eight byte enables set is committed without a read phase. `req_ready` stays high in the response cycle, and `rsp_valid` is high one cycle after acceptance.
- R2: A write with any byte enable clear holds `req_ready` low for exactly one cycle after acceptance. It stores the old word with only the enabled bytes (byte b is bits 8b+7..8b) replaced, and writes fresh check bits, so a later read with checking on raises no alarm.
- R3: When checking is on and the read phase of a merge finds an uncorrectable word, the write is cancelled. The stored data stays exactly as it was.
- R4: A cancelled merge sets `rmw_err_flag`, which stays set until a control write with bit 3 set clears it.
- R5: With checking on and error suppression off, a read of a word with two flipped bits returns `rsp_err`=1.
- R6: While `cfg_quiet`=1, no response carries `rsp_err`, including for uncorrectable words.
- R7: `alarm` is high in the response cycle of every read or merge that meets a one-bit or two-bit error, whatever `cfg_quiet` holds. A one-bit error is corrected in the returned data, and no error is flagged on the bus.
- R8: Control write fields: bit 0 enables checking, bit 1 is the new suppression value, bit 2 is its guard, bit 3 clears the sticky flag. `cfg_quiet` takes bit 1 only when bit 2 is 1; otherwise it keeps its value.
- R9: With checking off, writes store data bits only and leave the stored check bits unchanged. Reads return raw data with no alarm or error. Narrow writes merge raw data and are never cancelled.
- R10: Every single-bit error in any of the 64 data bits is corrected, and every two-bit data error is detected, not miscorrected.
- R11: After reset `req_ready`=1, `rsp_valid`=0, `alarm`=0, `rsp_err`=0, checking is on, `cfg_quiet`=0 and `rmw_err_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables, bit b covers data bits 8b+7..8b |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 64 | Read data (zero for writes) |
| rsp_err | output | 1 | Uncorrectable error reported to the bus |
| alarm | output | 1 | Pulse on any detected ECC error |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Control write fields (see R8) |
| cfg_check_en | output | 1 | Integrity checking enabled |
| cfg_quiet | output | 1 | Bus error report suppressed |
| rmw_err_flag | output | 1 | Sticky: a merge was cancelled |

## Verification
The storage path is tried with distinct data patterns in every word. Errors are injected through the ports, by rewriting a word with checking off so that its old check bits stay behind. This lets the bench place single flips at each of the 64 data bit positions, which shows correction is position-exact. Two-bit flips over many position pairs separate detection from miscorrection. Merges are swept over all 256 byte-enable values, which tells the direct full-word path apart from every partial merge and shows that each byte lane is steered on its own. Uncorrectable merges are run with suppression on and off, and with checking off. Together these runs separate cancellation, the sticky flag, bus reporting and the alarm.

// File: rtl/ecc_pkg.sv
`timescale 1ns/1ps
package ecc_pkg;
  localparam int unsigned DW   = 64;
  localparam int unsigned CW   = 8;
  localparam int unsigned NB   = DW / 8;
  localparam int unsigned SW   = CW - 1;
  localparam int unsigned CODE = DW + CW;

  typedef enum logic [0:0] {ST_IDLE, ST_MERGE} ctl_state_e;

  // Hamming position of data bit j: the j-th non-power-of-two index from 3 up.
  function automatic int unsigned hpos(int unsigned j);
    int unsigned p;
    int unsigned n;
    p = 0;
    n = 0;
    for (int unsigned k = 3; k < 128; k++) begin
      if ((k & (k - 1)) != 0) begin
        if (n == j && p == 0) p = k;
        n++;
      end
    end
    return p;
  endfunction

  // Data bits that contribute to check bit i.
  function automatic logic [DW-1:0] cover_mask(int unsigned i);
    logic [DW-1:0] m;
    for (int unsigned j = 0; j < DW; j++) m[j] = ((hpos(j) >> i) & 1) != 0;
    return m;
  endfunction
endpackage

// File: rtl/ecc_encode.sv
`timescale 1ns/1ps
module ecc_encode
  import ecc_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  logic [SW-1:0] ham;

  for (genvar i = 0; i < SW; i++) begin : g_chk
    localparam logic [DW-1:0] MASK = cover_mask(i);
    assign ham[i] = ^(data_i & MASK);
  end

  // Overall parity covers data and the Hamming bits.
  assign chk_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/ecc_check.sv
`timescale 1ns/1ps
module ecc_check
  import ecc_pkg::*;
(
  input  logic [CODE-1:0] code_i,
  output logic [DW-1:0]   data_o,
  output logic            single_o,
  output logic            double_o
);
  logic [DW-1:0] raw;
  logic [CW-1:0] stored;
  logic [SW-1:0] syn;
  logic          odd;

  assign raw    = code_i[DW-1:0];
  assign stored = code_i[CODE-1:DW];
  assign odd    = ^code_i;

  for (genvar i = 0; i < SW; i++) begin : g_syn
    localparam logic [DW-1:0] MASK = cover_mask(i);
    assign syn[i] = stored[i] ^ (^(raw & MASK));
  end

  for (genvar j = 0; j < DW; j++) begin : g_fix
    localparam int unsigned P = hpos(j);
    assign data_o[j] = raw[j] ^ (odd && (syn == SW'(P)));
  end

  assign single_o = odd;
  assign double_o = !odd && (syn != '0);
endmodule

// File: rtl/ecc_store.sv
`timescale 1ns/1ps
module ecc_store
  import ecc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [CODE-1:0] rd_code,
  input  logic            wr_data_en,
  input  logic            wr_chk_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [CW-1:0]   wr_chk
);
  logic [DW-1:0] data_mem [DEPTH];
  logic [CW-1:0] chk_mem  [DEPTH];
  logic [CODE-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_data_en) data_mem[wr_addr] <= wr_data;
    if (wr_chk_en)  chk_mem[wr_addr]  <= wr_chk;
    if (rd_en)      rd_q <= {chk_mem[rd_addr], data_mem[rd_addr]};
  end

  assign rd_code = rd_q;
endmodule

// File: rtl/ecc_sram_ctrl.sv
`timescale 1ns/1ps
module ecc_sram_ctrl
  import ecc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  input  logic [7:0]    req_be,
  output logic          rsp_valid,
  output logic [63:0]   rsp_rdata,
  output logic          rsp_err,
  output logic          alarm,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_wdata,
  output logic          cfg_check_en,
  output logic          cfg_quiet,
  output logic          rmw_err_flag
);
  // reset synchroniser: asserts at once, releases on the clock
  logic rst_s0, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_n_s <= rst_s0;
    end
  end

  ctl_state_e    state_q, state_d;
  logic          rd_pend_q, rd_pend_d;
  logic          wack_q, wack_d;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;
  logic [NB-1:0] hold_be_q;
  logic          check_en_q, check_en_d;
  logic          quiet_q, quiet_d;
  logic          rmw_flag_q, rmw_flag_d;

  logic            accept, full_word, in_merge, decode_live, cancel;
  logic            rd_en, wr_data_en, wr_chk_en;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data, merged, fixed_data, use_data;
  logic [CW-1:0]   wr_chk;
  logic [CODE-1:0] rd_code;
  logic            err_one, err_two;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign full_word   = &req_be;
  assign in_merge    = (state_q == ST_MERGE);
  assign decode_live = rd_pend_q || in_merge;
  assign cancel      = in_merge && check_en_q && err_two;

  ecc_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rd_en(rd_en), .rd_addr(req_addr), .rd_code(rd_code),
    .wr_data_en(wr_data_en), .wr_chk_en(wr_chk_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_chk(wr_chk)
  );

  ecc_check u_check (
    .code_i(rd_code), .data_o(fixed_data), .single_o(err_one), .double_o(err_two)
  );

  ecc_encode u_encode (.data_i(wr_data), .chk_o(wr_chk));

  assign use_data = check_en_q ? fixed_data : rd_code[DW-1:0];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign merged[8*b +: 8] = hold_be_q[b] ? hold_data_q[8*b +: 8] : use_data[8*b +: 8];
  end

  // storage port steering
  always_comb begin
    rd_en      = accept && (!req_write || !full_word);
    wr_data_en = 1'b0;
    wr_addr    = req_addr;
    wr_data    = req_wdata;
    if (in_merge) begin
      wr_data_en = !cancel;
      wr_addr    = hold_addr_q;
      wr_data    = merged;
    end else if (accept && req_write && full_word) begin
      wr_data_en = 1'b1;
    end
    wr_chk_en = wr_data_en && check_en_q;
  end

  // next state
  always_comb begin
    state_d    = state_q;
    rd_pend_d  = accept && !req_write;
    wack_d     = accept && req_write && full_word;
    check_en_d = check_en_q;
    quiet_d    = quiet_q;
    rmw_flag_d = rmw_flag_q;
    case (state_q)
      ST_IDLE:  if (accept && req_write && !full_word) state_d = ST_MERGE;
      ST_MERGE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    if (cfg_we) begin
      check_en_d = cfg_wdata[0];
      if (cfg_wdata[2]) quiet_d = cfg_wdata[1];
      if (cfg_wdata[3]) rmw_flag_d = 1'b0;
    end
    if (cancel) rmw_flag_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      rd_pend_q  <= 1'b0;
      wack_q     <= 1'b0;
      check_en_q <= 1'b1;
      quiet_q    <= 1'b0;
      rmw_flag_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_pend_q  <= rd_pend_d;
      wack_q     <= wack_d;
      check_en_q <= check_en_d;
      quiet_q    <= quiet_d;
      rmw_flag_q <= rmw_flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hold_addr_q <= '0;
      hold_data_q <= '0;
      hold_be_q   <= '0;
    end else if (accept) begin
      hold_addr_q <= req_addr;
      hold_data_q <= req_wdata;
      hold_be_q   <= req_be;
    end
  end

  assign rsp_valid    = rd_pend_q || wack_q || in_merge;
  assign rsp_rdata    = rd_pend_q ? use_data : '0;
  assign alarm        = decode_live && check_en_q && (err_one || err_two);
  assign rsp_err      = decode_live && check_en_q && err_two && !quiet_q;
  assign cfg_check_en = check_en_q;
  assign cfg_quiet    = quiet_q;
  assign rmw_err_flag = rmw_flag_q;

  assert_full_write_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && req_write && full_word) |=> (req_ready && rsp_valid && !rsp_err));
  assert_merge_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && req_write && !full_word) |=> (!req_ready ##1 req_ready));
  assert_flag_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rmw_flag_q) |-> $past(in_merge));
  assert_cancel_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_merge && check_en_q && err_two) |=> rmw_flag_q);
  assert_quiet_blocks_err_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    quiet_q |-> !rsp_err);
  assert_err_has_alarm_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> alarm);
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(cfg_we && cfg_wdata[2]) |=> $stable(quiet_q));
  assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !check_en_q |-> !alarm);
  assert_one_response_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({rd_pend_q, wack_q, in_merge}));
endmodule

// File: tb/ecc_sram_ctrl_test.sv
`timescale 1ns/1ps
module ecc_sram_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, alarm, cfg_check_en, cfg_quiet, rmw_err_flag;
  logic [63:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic        r_valid, r_err, r_alarm, r_ready, r_ready_next;
  logic [63:0] r_data;

  always #2.5 clk = ~clk;

  ecc_sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .alarm(alarm),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_check_en(cfg_check_en),
    .cfg_quiet(cfg_quiet), .rmw_err_flag(rmw_err_flag)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input int a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = 4'(a); req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_valid = rsp_valid; r_err = rsp_err; r_alarm = alarm; r_ready = req_ready; r_data = rsp_rdata;
    @(negedge clk);
    r_ready_next = req_ready;
  endtask

  task automatic cfg(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [63:0] pat(input int a);
    return {32'(a) * 32'h9E37_79B1 ^ 32'h0F0F_1234, ~(32'(a) * 32'h85EB_CA6B) ^ 32'h5A5A_0001};
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return m;
  endfunction

  // leave base's check bits behind and store base^flip as data (checking stays on afterwards)
  task automatic corrupt(input int a, input logic [63:0] base, input logic [63:0] flip);
    bus(1, a, base, 8'hFF);
    cfg(4'b0000);
    bus(1, a, base ^ flip, 8'hFF);
    cfg(4'b0001);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11 ready", 64'(req_ready), 64'd1);
    check("R11 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R11 alarm/err", 64'({alarm, rsp_err}), 64'd0);
    check("R11 check_en", 64'(cfg_check_en), 64'd1);
    check("R11 quiet", 64'(cfg_quiet), 64'd0);
    check("R11 flag", 64'(rmw_err_flag), 64'd0);

    // R1 full writes then reads
    for (int a = 0; a < 16; a++) begin
      bus(1, a, pat(a), 8'hFF);
      check("R1 full write no stall", 64'({r_valid, r_ready, r_err}), 64'b110);
    end
    for (int a = 0; a < 16; a++) begin
      bus(0, a, '0, 8'h00);
      check("R1 readback", r_data, pat(a));
      check("R1 clean read", 64'({r_valid, r_alarm, r_err}), 64'b100);
    end

    // R2 merge sweep over every byte-enable value
    begin
      logic [63:0] cur;
      cur = pat(5);
      for (int be = 0; be < 256; be++) begin
        logic [63:0] nd;
        nd = pat(be + 100);
        bus(1, 5, nd, 8'(be));
        if (be != 255) begin
          check("R2 stall one cycle", 64'({r_valid, r_ready, r_ready_next}), 64'b101);
        end else begin
          check("R1 full no stall", 64'({r_valid, r_ready}), 64'b11);
        end
        cur = merge(cur, nd, 8'(be));
        bus(0, 5, '0, 8'h00);
        check("R2 merged data", r_data, cur);
        check("R2 fresh check bits", 64'({r_alarm, r_err}), 64'b0);
      end
    end

    // R10 / R7 single-bit sweep
    for (int b = 0; b < 64; b++) begin
      logic [63:0] base;
      base = pat(b + 7);
      corrupt(3, base, 64'd1 << b);
      bus(0, 3, '0, 8'h00);
      check("R10 single corrected", r_data, base);
      check("R7 single alarm no err", 64'({r_alarm, r_err}), 64'b10);
    end

    // R10 / R5 double-bit detection
    for (int b = 0; b < 64; b++) begin
      int c;
      c = (b + 1 + (b % 13) * 4) % 64;
      corrupt(4, pat(b), (64'd1 << b) | (64'd1 << c));
      bus(0, 4, '0, 8'h00);
      check("R5 double err", 64'({r_alarm, r_err}), 64'b11);
    end

    // R7 merge over a single error corrects and merges
    corrupt(6, pat(60), 64'd1 << 40);
    bus(1, 6, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
    check("R7 merge single alarm", 64'({r_alarm, r_err}), 64'b10);
    bus(0, 6, '0, 8'h00);
    check("R7 merge single data", r_data, merge(pat(60), 64'hFF, 8'h01));
    check("R7 merged word clean", 64'(r_alarm), 64'd0);

    // R3 / R4 cancelled merge
    corrupt(7, pat(70), 64'h0000_0000_0001_0002);
    bus(1, 7, 64'h1111_2222_3333_4444, 8'h0F);
    check("R3 cancel err", 64'({r_valid, r_alarm, r_err}), 64'b111);
    check("R4 flag set", 64'(rmw_err_flag), 64'd1);
    cfg(4'b0000);
    bus(0, 7, '0, 8'h00);
    check("R3 data unchanged", r_data, pat(70) ^ 64'h0000_0000_0001_0002);
    cfg(4'b0001);
    check("R4 flag sticky", 64'(rmw_err_flag), 64'd1);
    cfg(4'b1001);
    check("R4 flag cleared", 64'(rmw_err_flag), 64'd0);

    // R8 guard on suppression bit
    cfg(4'b0011);
    check("R8 unguarded ignored", 64'(cfg_quiet), 64'd0);
    cfg(4'b0111);
    check("R8 guarded set", 64'(cfg_quiet), 64'd1);
    cfg(4'b0001);
    check("R8 unguarded clear ignored", 64'(cfg_quiet), 64'd1);

    // R6 suppression: alarm still fires
    bus(0, 4, '0, 8'h00);
    check("R6 quiet read", 64'({r_alarm, r_err}), 64'b10);
    bus(1, 7, 64'hAB, 8'h01);
    check("R6 quiet cancel", 64'({r_alarm, r_err}), 64'b10);
    check("R4 quiet cancel flag", 64'(rmw_err_flag), 64'd1);
    cfg(4'b0101);
    check("R8 guarded clear", 64'(cfg_quiet), 64'd0);
    cfg(4'b1001);

    // R9 checking off
    cfg(4'b0000);
    check("R9 check off", 64'(cfg_check_en), 64'd0);
    bus(0, 7, '0, 8'h00);
    check("R9 raw read", r_data, pat(70) ^ 64'h0000_0000_0001_0002);
    check("R9 silent", 64'({r_alarm, r_err}), 64'b0);
    bus(1, 7, 64'h0000_0000_CAFE_F00D, 8'h0F);
    check("R9 narrow no cancel", 64'({r_alarm, r_err, rmw_err_flag}), 64'b0);
    bus(0, 7, '0, 8'h00);
    check("R9 narrow merged raw", r_data,
          merge(pat(70) ^ 64'h0000_0000_0001_0002, 64'h0000_0000_CAFE_F00D, 8'h0F));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule